// File: doc/BRIEF.md
# SD Host Interrupt Status and Mask Unit

This unit gathers the event flags of an SD host controller and turns them into one active-low interrupt request. Eight events are latched into a 32-bit status word: command done, command timeout, CRC error, data end, card inserted, card removed, receive ready and transmit request. Two live level inputs are also shown in that word: write protect and command busy. A 32-bit mask word sits beside it. A mask bit at 1 blocks its event from the interrupt.

Software reaches both 32-bit words through a 16-bit register bus, one half at a time. It clears events by writing zeros to the status word. A second, 16-bit status and mask pair holds the card I/O interrupt event, and it drives the same interrupt line. The interrupt output is registered, and software treats its falling edge as the trigger.

Top module: `sdh_irq_unit`

## Requirements
- R1: After a synchronous reset, every latched status bit reads 0, both mask words read all ones (0xFFFF per half), the read data is 0 and `irq_n` is 1.
- R2: An event input high at a clock edge sets its status bit at that edge, and the bit stays set until software clears it. Bit positions are: command done 0, data end 2, card removed 3, card inserted 4, CRC error 16, command timeout 22, receive ready 24, transmit request 25.
- R3: A write to a status half clears each latched bit written as 0 and leaves each bit written as 1 unchanged. The other half is not affected. The low half is at byte offset 0x0 and the high half at 0x2.
- R4: When an event arrives in the same cycle as a write that clears its bit, the bit stays set.
- R5: An event is pending when its status bit is 1 and its mask bit is 0. `irq_n` is 0 one cycle after any bit is pending, from either pair, and is 1 one cycle after nothing is pending.
- R6: The mask halves can be written and read back in full. The low half is at 0x4 and the high half at 0x6.
- R7: Write protect (status bit 7) and command busy (status bit 30) read as the current level of their inputs. Writes do not change them, and they never cause an interrupt.
- R8: The I/O status word at 0x8 latches the card I/O event in bit 0 and is cleared by writing 0 to that bit, with an event in the same cycle taking priority over the clear. The I/O mask word at 0xA resets to 0xFFFF. Bit 0 of this mask gates the I/O event onto `irq_n`.
- R9: Read data appears one cycle after the address is presented. Odd addresses and offsets 0xC and 0xE read as 0, and writes to them have no effect. Status bits with no event or level behind them always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Write strobe for the register bus |
| reg_addr | input | 4 | Byte address of the 16-bit register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data for the address of the previous cycle |
| ev_cmd_done | input | 1 | Command response finished |
| ev_cmd_tmo | input | 1 | Command response timed out |
| ev_crc_err | input | 1 | CRC check failed |
| ev_data_end | input | 1 | Data transfer finished |
| ev_card_ins | input | 1 | Card inserted |
| ev_card_rem | input | 1 | Card removed |
| ev_rx_rdy | input | 1 | Receive buffer has data |
| ev_tx_req | input | 1 | Transmit buffer wants data |
| ev_io_irq | input | 1 | Card I/O interrupt event |
| lvl_wprot | input | 1 | Live write-protect level |
| lvl_cmd_busy | input | 1 | Live command-busy level |
| irq_n | output | 1 | Interrupt request, active low, registered |

## Verification
The hardest case to reach from the ports is a clearing write that lands in the same cycle as a new event on the bit being cleared, together with the interrupt line staying low across that cycle. A directed step lines up a data-end pulse with a zero write to its status half. The random phase then drives events at a high rate while it writes status halves with data that is mostly ones. This produces many cycles where an event and a clear hit the same half, and the bench model predicts each read and each `irq_n` value.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;

  localparam int BUS_W  = 16;
  localparam int STAT_W = 32;
  localparam int IO_W   = 16;

  // status word bit positions (main pair)
  localparam int B_CMD_DONE = 0;
  localparam int B_DATA_END = 2;
  localparam int B_CARD_REM = 3;
  localparam int B_CARD_INS = 4;
  localparam int B_WPROT    = 7;
  localparam int B_CRC_ERR  = 16;
  localparam int B_CMD_TMO  = 22;
  localparam int B_RX_RDY   = 24;
  localparam int B_TX_REQ   = 25;
  localparam int B_CMD_BUSY = 30;

  // I/O pair bit position
  localparam int B_IO_IRQ = 0;

  localparam logic [STAT_W-1:0] EVT_BITS =
      (STAT_W'(1) << B_CMD_DONE) | (STAT_W'(1) << B_DATA_END) |
      (STAT_W'(1) << B_CARD_REM) | (STAT_W'(1) << B_CARD_INS) |
      (STAT_W'(1) << B_CRC_ERR)  | (STAT_W'(1) << B_CMD_TMO)  |
      (STAT_W'(1) << B_RX_RDY)   | (STAT_W'(1) << B_TX_REQ);

  localparam logic [IO_W-1:0] IO_EVT_BITS = IO_W'(1) << B_IO_IRQ;

endpackage

// File: rtl/sdh_irq_wzc.sv
// Latched event word cleared by writing zeros, one write strobe per bus half.
module sdh_irq_wzc #(
  parameter int W     = 32,
  parameter int BUS_W = 16,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [W/BUS_W-1:0]    wr_half,
  input  logic [BUS_W-1:0]      wdata,
  input  logic [W-1:0]          set_i,
  output logic [W-1:0]          q
);
  localparam int NH = W / BUS_W;

  logic [W-1:0] keep;

  generate
    for (genvar h = 0; h < NH; h++) begin : g_half
      assign keep[h*BUS_W +: BUS_W] = wr_half[h] ? wdata : {BUS_W{1'b1}};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= ((q & keep) | set_i) & IMPL;
  end
endmodule

// File: rtl/sdh_irq_maskreg.sv
// Plain read/write mask word, reset to all ones, written one half at a time.
module sdh_irq_maskreg #(
  parameter int W     = 32,
  parameter int BUS_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [W/BUS_W-1:0] wr_half,
  input  logic [BUS_W-1:0]   wdata,
  output logic [W-1:0]       q
);
  localparam int NH = W / BUS_W;

  generate
    for (genvar h = 0; h < NH; h++) begin : g_half
      always_ff @(posedge clk) begin
        if (rst)             q[h*BUS_W +: BUS_W] <= {BUS_W{1'b1}};
        else if (wr_half[h]) q[h*BUS_W +: BUS_W] <= wdata;
      end
    end
  endgenerate
endmodule

// File: rtl/sdh_irq_regif.sv
// Address decode and registered read mux.
// Slots (byte address / 2): status halves, mask halves, I/O status, I/O mask.
module sdh_irq_regif #(
  parameter int ADDR_W = 4,
  parameter int BUS_W  = 16,
  parameter int NH     = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [NH*BUS_W-1:0] stat_view,
  input  logic [NH*BUS_W-1:0] mask_q,
  input  logic [BUS_W-1:0]    io_view,
  input  logic [BUS_W-1:0]    io_mask_q,
  output logic [NH-1:0]       stat_wr,
  output logic [NH-1:0]       mask_wr,
  output logic                io_wr,
  output logic                iomask_wr,
  output logic [BUS_W-1:0]    reg_rdata
);
  localparam int IW = ADDR_W - 1;

  logic [IW-1:0]    slot;
  logic             aligned;
  logic [BUS_W-1:0] rd_n;

  assign slot    = reg_addr[ADDR_W-1:1];
  assign aligned = ~reg_addr[0];

  generate
    for (genvar h = 0; h < NH; h++) begin : g_dec
      assign stat_wr[h] = reg_we && aligned && (slot == IW'(h));
      assign mask_wr[h] = reg_we && aligned && (slot == IW'(NH + h));
    end
  endgenerate

  assign io_wr     = reg_we && aligned && (slot == IW'(2*NH));
  assign iomask_wr = reg_we && aligned && (slot == IW'(2*NH + 1));

  always_comb begin
    rd_n = '0;
    if (aligned) begin
      for (int h = 0; h < NH; h++) begin
        if (slot == IW'(h))      rd_n = stat_view[h*BUS_W +: BUS_W];
        if (slot == IW'(NH + h)) rd_n = mask_q[h*BUS_W +: BUS_W];
      end
      if (slot == IW'(2*NH))     rd_n = io_view;
      if (slot == IW'(2*NH + 1)) rd_n = io_mask_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_n;
  end
endmodule

// File: rtl/sdh_irq_unit.sv
module sdh_irq_unit
  import sdh_irq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        ev_cmd_done,
  input  logic        ev_cmd_tmo,
  input  logic        ev_crc_err,
  input  logic        ev_data_end,
  input  logic        ev_card_ins,
  input  logic        ev_card_rem,
  input  logic        ev_rx_rdy,
  input  logic        ev_tx_req,
  input  logic        ev_io_irq,
  input  logic        lvl_wprot,
  input  logic        lvl_cmd_busy,
  output logic        irq_n
);
  localparam int NH    = STAT_W / BUS_W;
  localparam int IO_NH = IO_W / BUS_W;

  logic [STAT_W-1:0] ev_set, stat_q, stat_view, mask_q;
  logic [IO_W-1:0]   io_set, io_stat_q, io_mask_q;
  logic [NH-1:0]     stat_wr, mask_wr;
  logic              io_wr, iomask_wr;
  logic              pend_main, pend_io, pending;

  always_comb begin
    ev_set             = '0;
    ev_set[B_CMD_DONE] = ev_cmd_done;
    ev_set[B_DATA_END] = ev_data_end;
    ev_set[B_CARD_REM] = ev_card_rem;
    ev_set[B_CARD_INS] = ev_card_ins;
    ev_set[B_CRC_ERR]  = ev_crc_err;
    ev_set[B_CMD_TMO]  = ev_cmd_tmo;
    ev_set[B_RX_RDY]   = ev_rx_rdy;
    ev_set[B_TX_REQ]   = ev_tx_req;
  end

  always_comb begin
    io_set           = '0;
    io_set[B_IO_IRQ] = ev_io_irq;
  end

  always_comb begin
    stat_view             = stat_q;
    stat_view[B_WPROT]    = lvl_wprot;
    stat_view[B_CMD_BUSY] = lvl_cmd_busy;
  end

  sdh_irq_regif #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .NH(NH)) u_regif (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .stat_view (stat_view),
    .mask_q    (mask_q),
    .io_view   (io_stat_q),
    .io_mask_q (io_mask_q),
    .stat_wr   (stat_wr),
    .mask_wr   (mask_wr),
    .io_wr     (io_wr),
    .iomask_wr (iomask_wr),
    .reg_rdata (reg_rdata)
  );

  sdh_irq_wzc #(.W(STAT_W), .BUS_W(BUS_W), .IMPL(EVT_BITS)) u_stat (
    .clk     (clk),
    .rst     (rst),
    .wr_half (stat_wr),
    .wdata   (reg_wdata),
    .set_i   (ev_set),
    .q       (stat_q)
  );

  sdh_irq_maskreg #(.W(STAT_W), .BUS_W(BUS_W)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .wr_half (mask_wr),
    .wdata   (reg_wdata),
    .q       (mask_q)
  );

  sdh_irq_wzc #(.W(IO_W), .BUS_W(BUS_W), .IMPL(IO_EVT_BITS)) u_io_stat (
    .clk     (clk),
    .rst     (rst),
    .wr_half (IO_NH'(io_wr)),
    .wdata   (reg_wdata),
    .set_i   (io_set),
    .q       (io_stat_q)
  );

  sdh_irq_maskreg #(.W(IO_W), .BUS_W(BUS_W)) u_io_mask (
    .clk     (clk),
    .rst     (rst),
    .wr_half (IO_NH'(iomask_wr)),
    .wdata   (reg_wdata),
    .q       (io_mask_q)
  );

  assign pend_main = |(stat_q & EVT_BITS & ~mask_q);
  assign pend_io   = |(io_stat_q & IO_EVT_BITS & ~io_mask_q);
  assign pending   = pend_main | pend_io;

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~pending;
  end
endmodule

// File: rtl/sdh_irq_chk.sv
module sdh_irq_chk (
  input logic        clk,
  input logic        rst,
  input logic        irq_n,
  input logic        pending,
  input logic [31:0] stat_q,
  input logic [15:0] io_stat_q,
  input logic        ev_cmd_done,
  input logic        ev_data_end,
  input logic        ev_io_irq,
  input logic        reg_we,
  input logic [3:0]  reg_addr,
  input logic [15:0] reg_wdata
);
  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> irq_n);

  p_event_sets_r2: assert property (@(posedge clk) disable iff (rst)
    ev_cmd_done |=> stat_q[0]);

  p_zero_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 4'h0 && !reg_wdata[0] && !ev_cmd_done) |=> !stat_q[0]);

  p_event_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 4'h0 && !reg_wdata[2] && ev_data_end) |=> stat_q[2]);

  p_irq_low_r5: assert property (@(posedge clk) disable iff (rst)
    pending |=> !irq_n);

  p_irq_high_r5: assert property (@(posedge clk) disable iff (rst)
    !pending |=> irq_n);

  p_io_latch_r8: assert property (@(posedge clk) disable iff (rst)
    ev_io_irq |=> io_stat_q[0]);
endmodule

bind sdh_irq_unit sdh_irq_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .irq_n       (irq_n),
  .pending     (pending),
  .stat_q      (stat_q),
  .io_stat_q   (io_stat_q),
  .ev_cmd_done (ev_cmd_done),
  .ev_data_end (ev_data_end),
  .ev_io_irq   (ev_io_irq),
  .reg_we      (reg_we),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata)
);

// File: tb/sdh_irq_unit_test.sv
`timescale 1ns/1ps
module sdh_irq_unit_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        reg_we = 0;
  logic [3:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic [8:0]  ev = 0;
  logic        lvl_wprot = 0, lvl_cmd_busy = 0;
  logic        irq_n;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // bench model
  logic [31:0] m_stat, m_mask;
  logic [15:0] m_io, m_iomask;

  always #10 clk = ~clk;

  sdh_irq_unit uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_cmd_done(ev[0]), .ev_data_end(ev[1]), .ev_card_rem(ev[2]),
    .ev_card_ins(ev[3]), .ev_crc_err(ev[4]), .ev_cmd_tmo(ev[5]),
    .ev_rx_rdy(ev[6]), .ev_tx_req(ev[7]), .ev_io_irq(ev[8]),
    .lvl_wprot(lvl_wprot), .lvl_cmd_busy(lvl_cmd_busy), .irq_n(irq_n)
  );

  localparam logic [31:0] EVT = 32'h0341_001D;

  function automatic logic [31:0] ev_word(input logic [8:0] e);
    logic [31:0] w = '0;
    w[0] = e[0]; w[2] = e[1]; w[3] = e[2]; w[4] = e[3];
    w[16] = e[4]; w[22] = e[5]; w[24] = e[6]; w[25] = e[7];
    return w;
  endfunction

  function automatic logic [15:0] exp_read(input logic [3:0] a);
    logic [31:0] v = m_stat;
    v[7] = lvl_wprot; v[30] = lvl_cmd_busy;
    case (a)
      4'h0: return v[15:0];
      4'h2: return v[31:16];
      4'h4: return m_mask[15:0];
      4'h6: return m_mask[31:16];
      4'h8: return m_io;
      4'hA: return m_iomask;
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic exp_pending();
    return (|(m_stat & EVT & ~m_mask)) | (m_io[0] & ~m_iomask[0]);
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input string tag, input logic we, input logic [3:0] a,
                      input logic [15:0] wd, input logic [8:0] e);
    logic [15:0] er;
    logic        ei;
    logic [31:0] keep;
    reg_we = we; reg_addr = a; reg_wdata = wd; ev = e;
    @(posedge clk);
    er = exp_read(a);
    ei = ~exp_pending();
    keep = 32'hFFFF_FFFF;
    if (we && a == 4'h0) keep[15:0]  = wd;
    if (we && a == 4'h2) keep[31:16] = wd;
    m_stat = ((m_stat & keep) | ev_word(e)) & EVT;
    if (we && a == 4'h4) m_mask[15:0]  = wd;
    if (we && a == 4'h6) m_mask[31:16] = wd;
    m_io = ((m_io & ((we && a == 4'h8) ? wd : 16'hFFFF)) | {15'd0, e[8]}) & 16'h0001;
    if (we && a == 4'hA) m_iomask = wd;
    @(negedge clk);
    reg_we = 0; ev = 0;
    check({tag, " rdata"}, reg_rdata, er);
    check({tag, " irq_n"}, {15'd0, irq_n}, {15'd0, ei});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_stat = 0; m_mask = '1; m_io = 0; m_iomask = 16'hFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check("R1 rdata after reset", reg_rdata, 16'h0);
    check("R1 irq_n after reset", {15'd0, irq_n}, 16'h1);

    // R1: read every register
    for (int i = 0; i < 6; i++) step("R1", 0, 4'(2*i), 0, 0);
    step("R1", 0, 4'h0, 0, 0);

    // R2: events latch and hold
    step("R2", 0, 4'h0, 0, 9'h001);
    step("R2", 0, 4'h0, 0, 0);
    step("R2", 0, 4'h2, 0, 9'h010);
    step("R2", 0, 4'h2, 0, 0);
    step("R2", 0, 4'h0, 0, 9'h00E);
    step("R2", 0, 4'h2, 0, 9'h0E0);
    step("R2", 0, 4'h0, 0, 0);
    step("R2", 0, 4'h2, 0, 0);

    // R5: masked events keep irq high, unmasking drives it low
    step("R5", 1, 4'h4, 16'hFFFE, 0);
    step("R5", 0, 4'h4, 0, 0);
    step("R5", 0, 4'h0, 0, 0);

    // R3: clear bit 0 only, high half untouched
    step("R3", 1, 4'h0, 16'hFFFE, 0);
    step("R3", 0, 4'h0, 0, 0);
    step("R3", 0, 4'h2, 0, 0);
    step("R3", 1, 4'h2, 16'h0000, 0);
    step("R3", 0, 4'h2, 0, 0);

    // R4: event beats simultaneous clear
    step("R4", 1, 4'h4, 16'hFFFB, 0);
    step("R4", 1, 4'h0, 16'h0000, 9'h002);
    step("R4", 0, 4'h0, 0, 0);
    step("R4", 0, 4'h0, 0, 0);
    step("R4", 1, 4'h0, 16'h0000, 0);
    step("R4", 0, 4'h0, 0, 0);

    // R6: mask read back
    step("R6", 1, 4'h6, 16'h1234, 0);
    step("R6", 0, 4'h6, 0, 0);
    step("R6", 1, 4'h6, 16'hFFFF, 0);

    // R7: live levels, unaffected by writes, no interrupt
    lvl_wprot = 1; lvl_cmd_busy = 1;
    step("R7", 1, 4'h4, 16'h0000, 0);
    step("R7", 1, 4'h6, 16'h0000, 0);
    step("R7", 1, 4'h0, 16'h0000, 0);
    step("R7", 1, 4'h2, 16'h0000, 0);
    step("R7", 0, 4'h0, 0, 0);
    step("R7", 0, 4'h2, 0, 0);
    lvl_wprot = 0;
    step("R7", 0, 4'h0, 0, 0);

    // R8: I/O pair
    step("R8", 0, 4'h8, 0, 9'h100);
    step("R8", 0, 4'h8, 0, 0);
    step("R8", 1, 4'hA, 16'hFFFE, 0);
    step("R8", 0, 4'hA, 0, 0);
    step("R8", 0, 4'h8, 0, 0);
    step("R8", 1, 4'h8, 16'h0000, 9'h100);
    step("R8", 0, 4'h8, 0, 0);
    step("R8", 1, 4'h8, 16'h0000, 0);
    step("R8", 0, 4'h8, 0, 0);
    step("R8", 0, 4'h8, 0, 0);

    // R9: unmapped and odd addresses
    step("R9", 0, 4'hC, 0, 9'h001);
    step("R9", 1, 4'h1, 16'h0000, 0);
    step("R9", 1, 4'hE, 16'h0000, 0);
    step("R9", 0, 4'h1, 0, 0);
    step("R9", 0, 4'h0, 0, 0);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      logic [8:0]  e;
      logic [3:0]  a;
      logic [15:0] wd;
      logic        we;
      for (int b = 0; b < 9; b++) e[b] = ($urandom % 5) == 0;
      a  = 4'($urandom % 16);
      if (($urandom % 4) != 0) a[0] = 1'b0;
      we = ($urandom % 3) == 0;
      wd = 16'($urandom);
      if (a == 4'h0 || a == 4'h2 || a == 4'h8)
        wd = ~(16'($urandom) & 16'($urandom) & 16'($urandom));
      if (($urandom % 50) == 0) lvl_wprot = ~lvl_wprot;
      if (($urandom % 50) == 0) lvl_cmd_busy = ~lvl_cmd_busy;
      step("R5 random", we, a, wd, e);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule